// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one 16-bit timer channel built around a single data word. A mode input chooses what that word means. In compare mode it is an interval: a down-counter loads from it, steps once per count-enable tick, and raises a one-cycle interrupt when a tick finds the counter at zero. On that tick the counter reloads, so the interval repeats. In capture mode a free-running up-counter steps on each tick. A selected edge on the timer input pin latches the counter's current value into the data word.

Software reaches the data word through a plain full-width write strobe and a continuously visible read value. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. A write is accepted in the cycle its strobe is high. The read value always shows the register's present contents.

Top module: `cc_timer_chan`

## Requirements
- R1: After reset, `rd_data` is 0x0000 and `irq` is low.
- R2: A write (`wr_en` high) while `mode` is 0 (compare) stores `wr_data`, which appears on `rd_data` one cycle later. The same write restarts the counter at that value. In compare mode the stored word does not change until the next write.
- R3: In compare mode each tick decrements the counter. A tick that finds the counter at zero reloads it from the data word and sets `irq` high for exactly one cycle after that edge. With the data word at N and `tick` held high, `irq` therefore pulses once every N+1 cycles.
- R4: In compare mode, while `tick` is low the counter holds and `irq` stays low.
- R5: In capture mode (`mode` = 1) the counter starts at 0x0000, adds one per tick and wraps from 0xFFFF to 0x0000. A valid edge copies the counter into the data word.
- R6: `edge_sel` selects the valid edge: 00 rising, 01 falling, 10 both. The value 11 accepts no edge.
- R7: The pin passes through a two-flop synchronizer. A pin change set up before clock edge k is captured, and shown on `irq` and `rd_data`, after edge k+2.
- R8: In capture mode `irq` goes high for one cycle for each capture and at no other time.
- R9: In compare mode, edges on the pin change neither the data word nor `irq`.
- R10: When a write and a capture fall in the same cycle, the captured counter value is stored and the written value is dropped.
- R11: Any change of `mode` clears the counter to 0x0000.
- R12: A write in capture mode stores `wr_data` and leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | 0 compare, 1 capture |
| edge_sel | input | 2 | Valid edge: 00 rise, 01 fall, 10 both, 11 none |
| tmr_in | input | 1 | Asynchronous timer input pin |
| tick | input | 1 | Count enable, one step per high cycle |
| wr_en | input | 1 | Write strobe for the data word |
| wr_data | input | 16 | Value to write |
| rd_data | output | 16 | Current data word |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The counter itself is not a port, so a wrong count can only be seen through its effects. In compare mode an error moves the position of the next `irq` pulse, which becomes visible within one interval of N+1 ticks. In capture mode an error shows up in the value latched on the next capture, at most three cycles after a pin edge. A broken synchronizer or edge decoder shows up as an `irq` on the wrong cycle or on the wrong edge.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;

  localparam logic MODE_CMP = 1'b0;
  localparam logic MODE_CAP = 1'b1;
endpackage

// File: rtl/cct_edge_det.sv
module cct_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       hit
);
  import cct_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= pin;
        else sync_q[i] <= sync_q[(i > 0) ? i - 1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else prev_q <= sync_q[SYNC_STAGES-1];
  end

  logic now_s, rise, fall;
  assign now_s = sync_q[SYNC_STAGES-1];
  assign rise  = now_s & ~prev_q;
  assign fall  = ~now_s & prev_q;

  always_comb begin
    case (edge_sel_e'(sel))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_mode,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt,
  output logic         zero_hit
);
  logic mode_q;
  logic mode_chg;
  logic at_zero;

  assign mode_chg = cap_mode ^ mode_q;
  assign at_zero  = (cnt == '0);
  assign zero_hit = !cap_mode && !mode_chg && !load && tick && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else mode_q <= cap_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (mode_chg) begin
      cnt <= '0;
    end else if (cap_mode) begin
      if (tick) cnt <= cnt + 1'b1;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick) begin
      cnt <= at_zero ? reload_val : cnt - 1'b1;
    end
  end
endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan #(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode,
  input  logic [1:0]   edge_sel,
  input  logic         tmr_in,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         irq
);
  import cct_pkg::*;

  logic         edge_hit;
  logic         cap_evt;
  logic         zero_hit;
  logic [W-1:0] cnt;
  logic [W-1:0] data_q;
  logic         irq_q;
  logic         is_cap;

  assign is_cap  = (mode == MODE_CAP);
  assign cap_evt = is_cap & edge_hit;

  cct_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (tmr_in),
    .sel   (edge_sel),
    .hit   (edge_hit)
  );

  cct_counter #(.W(W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_mode   (is_cap),
    .tick       (tick),
    .load       (wr_en),
    .load_val   (wr_data),
    .reload_val (data_q),
    .cnt        (cnt),
    .zero_hit   (zero_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (cap_evt) data_q <= cnt;
      else if (wr_en) data_q <= wr_data;
      irq_q <= zero_hit | cap_evt;
    end
  end

  assign rd_data = data_q;
  assign irq     = irq_q;
endmodule

// File: rtl/cct_chk.sv
module cct_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode,
  input logic [1:0]   edge_sel,
  input logic         tick,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] rd_data,
  input logic         irq
);
  // R2
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 1'b0 && !wr_en) |=> $stable(rd_data));

  // R2
  cmp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 1'b0 && wr_en) |=> (rd_data == $past(wr_data)));

  // R4
  cmp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 1'b0 && !tick) |=> !irq);

  // R6
  no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 1'b1 && edge_sel == 2'b11) |=> !irq);

  // R6
  no_edge_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 1'b1 && edge_sel == 2'b11 && !wr_en) |=> $stable(rd_data));
endmodule

bind cc_timer_chan cct_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .edge_sel (edge_sel),
  .tick     (tick),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .irq      (irq)
);

// File: tb/cc_timer_chan_tb.sv
module cc_timer_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic [1:0]  edge_sel = 2'b00;
  logic        tmr_in = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cc_timer_chan u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .edge_sel(edge_sel),
    .tmr_in(tmr_in), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n - 1) @(negedge clk);
      @(negedge clk); tick = 1'b0;
    end
  endtask

  // Set the pin, then report whether irq appears on the first two
  // negedges (should not) and on the third (capture cycle, R7).
  task automatic pin_to(input logic v, output logic early, output logic late);
    @(negedge clk); tmr_in = v;
    @(negedge clk); early = irq;
    @(negedge clk); early = early | irq;
    @(negedge clk); late = irq;
    @(negedge clk); late = late & !irq;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic e, l;
    int base;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 data", rd_data, 16'h0);
    chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3: compare interval sweep
    for (int n = 0; n < 8; n++) begin
      int bad;
      bad = 0;
      do_write(16'(n));
      chk("R2 readback", rd_data, 32'(n));
      tick = 1'b1;
      for (int c = 1; c <= 3 * (n + 1); c++) begin
        @(negedge clk);
        if (irq !== ((c % (n + 1)) == 0)) bad++;
      end
      tick = 1'b0;
      chk("R3 period", bad, 0);
      // R4
      bad = 0;
      repeat (5) begin @(negedge clk); if (irq) bad++; end
      chk("R4 frozen", bad, 0);
    end

    // R4: counter holds without ticks; resume gives remaining count
    do_write(16'd6);
    do_ticks(3);
    repeat (4) @(negedge clk);
    begin
      int k;
      k = 0;
      tick = 1'b1;
      for (int c = 1; c <= 10; c++) begin
        @(negedge clk);
        if (irq && k == 0) k = c;
      end
      tick = 1'b0;
      chk("R4 resume", k, 4);
    end

    // R9: pin edges ignored in compare mode
    do_write(16'h1234);
    edge_sel = 2'b10;
    pin_to(1'b1, e, l);
    chk("R9 irq", e | l, 0);
    pin_to(1'b0, e, l);
    chk("R9 irq", e | l, 0);
    chk("R9 data", rd_data, 16'h1234);

    // R11: switch to capture clears counter; capture yields 0
    edge_sel = 2'b00;
    @(negedge clk); mode = 1'b1;
    @(negedge clk);
    pin_to(1'b1, e, l);
    chk("R7 early", e, 0);
    chk("R8 pulse", l, 1);
    chk("R11 cleared", rd_data, 16'h0);
    pin_to(1'b0, e, l);
    chk("R6 fall ignored", e | l, 0);

    // R5: capture sweep
    base = 0;
    for (int m = 1; m <= 6; m++) begin
      do_ticks(m);
      base += m;
      pin_to(1'b1, e, l);
      chk("R5 capture irq", l & !e, 1);
      chk("R5 capture value", rd_data, 32'(base));
      pin_to(1'b0, e, l);
    end

    // R12: write in capture mode; counter unaffected
    do_write(16'hBEEF);
    chk("R12 stored", rd_data, 16'hBEEF);
    pin_to(1'b1, e, l);
    chk("R12 counter", rd_data, 32'(base));
    pin_to(1'b0, e, l);

    // R6: edge select sweep
    for (int s = 0; s < 4; s++) begin
      int n_irq;
      n_irq = 0;
      edge_sel = 2'(s);
      do_ticks(1);
      base++;
      pin_to(1'b1, e, l); n_irq += l;
      pin_to(1'b0, e, l); n_irq += l;
      chk("R6 edge count", n_irq, (s == 2) ? 2 : (s == 3) ? 0 : 1);
    end

    // R10: write and capture in the same cycle
    edge_sel = 2'b00;
    do_ticks(2);
    base += 2;
    @(negedge clk); tmr_in = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_data = 16'hA5A5;
    @(negedge clk); wr_en = 1'b0;
    chk("R10 capture wins", rd_data, 32'(base));
    @(negedge clk); tmr_in = 1'b0;
    repeat (4) @(negedge clk);

    // R5 wrap: clear via mode toggle, count 0xFFFF then one more
    @(negedge clk); mode = 1'b0;
    @(negedge clk); mode = 1'b1;
    @(negedge clk);
    do_ticks(65535);
    pin_to(1'b1, e, l);
    chk("R5 max", rd_data, 16'hFFFF);
    pin_to(1'b0, e, l);
    do_ticks(1);
    pin_to(1'b1, e, l);
    chk("R5 wrap", rd_data, 16'h0000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule